// File: doc/BRIEF.md
# Self-Clocked Converter Readout Sequencer

This block is the digital front of a two-channel converter's serial port in the mode where the converter makes its own serial clock. Internally it moves through three phases: converting, sleeping with a finished result, and shifting that result out. A programmable cycle counter stands in for the conversion engine. When a conversion finishes, a 32-bit word is assembled from the result inputs and an alternating channel bit, and it is held in a shift register until it is read.

The host controls the port only through an active-low select line. While the host holds select low, the serial data pin first shows a busy/done flag. If the host keeps select low for a fixed test window after the block reaches the sleep phase, the block starts toggling its own serial clock and sends the 32-bit word MSB-first. If the host raises select before the first rising clock edge, the block stays asleep and keeps the word. If the host raises select after at least one rising edge, the readout stops and a new conversion starts at once.

The readout has no valid/ready handshake, because the pace is set only by the block's own serial clock. A receiver cannot stall the stream. It can only shorten it by deselecting, so it must capture a bit on every rising edge of `sck`.

Top module: `adc_serial_seq`

## Requirements
- R1: `sdo_oe` is 0 whenever `cs_n` is 1 and 1 whenever `cs_n` is 0.
- R2: After reset `sck` is 1. When `cs_n` falls outside a readout, `sck` is 0 in the next cycle. While selected, `sdo` is 1 during a conversion and 0 while sleeping.
- R3: If select is raised before the first rising `sck` edge of a readout, no rising `sck` edge occurs and the block returns to sleep. A later full readout delivers the same held word.
- R4: With `cs_n` low in the sleep phase, the first rising `sck` edge comes EOC_WINDOW+SCK_HALF clock cycles after the first sleeping cycle. The count runs from the cycle in which `cs_n` is first low if the block was already asleep.
- R5: During a readout, successive rising `sck` edges are 2*SCK_HALF clock cycles apart, and `sdo` changes only while `sck` is low.
- R6: The word is sent MSB-first with this layout: bit 31 = 0 (done flag), bit 30 = channel, bit 29 = `conv_sign_i`, bit 28 = `conv_over_i`, bits 27..4 = `conv_val_i` bits 23..0, bits 3..0 = 0. The inputs are sampled in the last cycle of the conversion.
- R7: Exactly 32 rising edges are produced. SCK_HALF cycles after the 32nd rising edge, `sck` stays 1, `sdo` becomes 1 and a new conversion begins.
- R8: Raising `cs_n` after the 1st and up to the 32nd rising edge ends the readout, and a conversion starts in the next cycle. It lasts CONV_CYCLES cycles before `sdo` reads 0 again.
- R9: The channel bit is 0 in the first word after reset and alternates on each completed conversion.
- R10: A conversion lasts CONV_CYCLES clock cycles, observed as that many consecutive cycles of `sdo` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select, synchronous to clk |
| conv_val_i | input | 24 | Conversion magnitude placed in bits 27..4 |
| conv_sign_i | input | 1 | Sign flag placed in bit 29 |
| conv_over_i | input | 1 | Extended-range flag placed in bit 28 |
| sck | output | 1 | Serial clock generated by the block |
| sdo | output | 1 | Serial data / status value |
| sdo_oe | output | 1 | Drive enable for sdo (0 = high impedance) |

## Verification
The assertions assume the following about the inputs:
- `cs_n` is already synchronous to `clk`.
- The three result inputs hold steady across the cycle in which a conversion ends.

The stimulus keeps within these assumptions. It changes `cs_n` only at falling clock edges. It changes the result inputs only just after a readout or abort, when the next conversion has tens of cycles left to run. The state-based properties also rely on select never falling while a readout is active; this holds because a high level on `cs_n` always ends the readout.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int WORD_W = 32;
  localparam int RES_W  = 24;
  localparam int PAD_W  = WORD_W - RES_W - 4;
  localparam int EDGE_W = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OUT   = 2'd2
  } seq_state_e;

  function automatic logic [WORD_W-1:0] pack_word(
    input logic             chan,
    input logic             sign,
    input logic             over,
    input logic [RES_W-1:0] val
  );
    return {1'b0, chan, sign, over, val, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/seq_terminal_count.sv
module seq_terminal_count #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic hit
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!en || hit) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_word_shifter.sv
module adc_word_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= load_word;
    else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb = sh_q[W-1];
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 200,
  parameter int unsigned EOC_WINDOW  = 12,
  parameter int unsigned SCK_HALF    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic [RES_W-1:0] conv_val_i,
  input  logic             conv_sign_i,
  input  logic             conv_over_i,
  output logic             sck,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(WORD_W);

  seq_state_e        state_q, state_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              sck_q, sck_d;
  logic              cs_q, chan_q;
  logic              conv_hit, win_hit, half_hit;
  logic              load_word, shift_word, shift_msb;
  logic              cs_fell;
  logic [WORD_W-1:0] new_word;

  assign cs_fell  = cs_q & ~cs_n;
  assign new_word = pack_word(chan_q, conv_sign_i, conv_over_i, conv_val_i);

  // conversion time
  seq_terminal_count #(.LIMIT(CONV_CYCLES)) u_conv_t (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state_q == ST_CONV),
    .hit  (conv_hit)
  );

  // status-test window, runs only while asleep and selected
  seq_terminal_count #(.LIMIT(EOC_WINDOW)) u_win_t (
    .clk  (clk),
    .rst_n(rst_n),
    .en   ((state_q == ST_SLEEP) && !cs_n),
    .hit  (win_hit)
  );

  // half-period divider for the generated serial clock
  seq_terminal_count #(.LIMIT(SCK_HALF)) u_half_t (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state_q == ST_OUT),
    .hit  (half_hit)
  );

  adc_word_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_word),
    .load_word(new_word),
    .shift    (shift_word),
    .msb      (shift_msb)
  );

  always_comb begin
    state_d    = state_q;
    edge_d     = edge_q;
    load_word  = 1'b0;
    shift_word = 1'b0;
    unique case (state_q)
      ST_CONV: begin
        if (conv_hit) begin
          state_d   = ST_SLEEP;
          load_word = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (win_hit) begin
          state_d = ST_OUT;
          edge_d  = '0;
        end
      end
      ST_OUT: begin
        if (cs_n) begin
          // before any rising edge: back to sleep, word kept
          state_d = (edge_q == '0) ? ST_SLEEP : ST_CONV;
        end else if (half_hit) begin
          if (!sck_q)                    edge_d     = edge_q + 1'b1;
          else if (edge_q == LAST_EDGE)  state_d    = ST_CONV;
          else                           shift_word = 1'b1;
        end
      end
      default: state_d = ST_CONV;
    endcase
  end

  always_comb begin
    sck_d = sck_q;
    if (cs_n) begin
      sck_d = 1'b1;
    end else if (state_q == ST_OUT) begin
      if (half_hit && !(sck_q && edge_q == LAST_EDGE)) sck_d = ~sck_q;
    end else if (cs_fell || win_hit) begin
      sck_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_CONV;
      edge_q  <= '0;
      sck_q   <= 1'b1;
      cs_q    <= 1'b1;
      chan_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      sck_q   <= sck_d;
      cs_q    <= cs_n;
      if (load_word) chan_q <= ~chan_q;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_OUT:  sdo = shift_msb;
      ST_CONV: sdo = 1'b1;
      default: sdo = 1'b0;
    endcase
  end

  assign sck    = sck_q;
  assign sdo_oe = ~cs_n;
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk
  import adc_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sck,
  input logic              sdo,
  input seq_state_e        state,
  input logic [EDGE_W-1:0] edge_cnt
);
  // R2: converting and selected shows busy
  a_r2_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && state == ST_CONV) |-> sdo);

  // R2: selecting outside a readout pulls sck low
  a_r2_sck_low_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && state != ST_OUT) |=> !sck);

  // R3: release before the first rising edge returns to sleep
  a_r3_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUT && cs_n && edge_cnt == '0) |=> (state == ST_SLEEP));

  // R5: edge count never passes the word length
  a_r5_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= EDGE_W'(WORD_W));

  // R5: data holds while sck is high
  a_r5_sdo_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUT && $past(state) == ST_OUT && sck && $past(sck)) |-> $stable(sdo));

  // R7: normal end leaves sck high and flag high
  a_r7_finish_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_OUT && state == ST_CONV && !$past(cs_n)) |-> (sck && sdo));

  // R8: abort after a rising edge restarts conversion
  a_r8_abort_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUT && cs_n && edge_cnt != '0) |=> (state == ST_CONV));
endmodule

bind adc_serial_seq adc_serial_seq_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .sck     (sck),
  .sdo     (sdo),
  .state   (state_q),
  .edge_cnt(edge_q)
);

// File: tb/adc_serial_seq_tb_top.sv
`timescale 1ns/1ps
module adc_serial_seq_tb_top;
  localparam int CONV = 60;
  localparam int EOCT = 8;
  localparam int HALF = 2;
  localparam int NW   = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic [23:0] val_i = '0;
  logic        sign_i = 1'b0;
  logic        over_i = 1'b0;
  logic        sck, sdo, sdo_oe;

  int  vectors = 0;
  int  miscompares = 0;
  int  cyc = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_seq #(
    .CONV_CYCLES(CONV),
    .EOC_WINDOW (EOCT),
    .SCK_HALF   (HALF)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .conv_val_i (val_i),
    .conv_sign_i(sign_i),
    .conv_over_i(over_i),
    .sck        (sck),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe)
  );

  function automatic logic [23:0] pat_val(int c);
    logic [31:0] h;
    case (c)
      0: return 24'h000000;
      1: return 24'hFFFFFF;
      2: return 24'h800000;
      3: return 24'h000001;
      4: return 24'h7FFFFF;
      default: begin
        h = 32'(c) * 32'h9E3779B1;
        return h[27:4];
      end
    endcase
  endfunction

  function automatic logic pat_sign(int c);
    return c[0] ^ c[1];
  endfunction

  function automatic logic pat_over(int c);
    return c[1];
  endfunction

  // R6 layout, R9 channel = conversion index parity
  function automatic logic [31:0] exp_word(int c);
    return {1'b0, c[0], pat_sign(c), pat_over(c), pat_val(c), 4'h0};
  endfunction

  task automatic set_inputs(int c);
    val_i  = pat_val(c);
    sign_i = pat_sign(c);
    over_i = pat_over(c);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_first_rise(output int n);
    bit seen_low = 1'b0;
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      n++;
      if (!sck) seen_low = 1'b1;
      else if (seen_low) return;
    end
  endtask

  // first bit is taken at the current (rise) sample
  task automatic read_bits(input int nb, output logic [31:0] w);
    int   got = 1;
    int   gap = 0;
    logic prev = sck;
    w = {31'b0, sdo};
    while (got < nb && gap < 1000) begin
      @(negedge clk);
      gap++;
      if (sck && !prev) begin
        check(gap == 2 * HALF, "R5", gap, 2 * HALF);
        w = {w[30:0], sdo};
        got++;
        gap = 0;
      end
      prev = sck;
    end
  endtask

  task automatic count_conv(output int zeros, output int ones, output bit sck_hi);
    zeros = 0;
    ones = 0;
    sck_hi = 1'b1;
    while (!sdo && zeros < 5000) begin
      zeros++;
      @(negedge clk);
    end
    while (sdo && ones < 5000) begin
      ones++;
      if (!sck && !cs_n) sck_hi = 1'b0;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog act=%0d exp<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int          n, z, o, c;
    bit          hi;
    logic [31:0] w;
    int          nbs [3] = '{1, 7, 31};

    set_inputs(0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sdo_oe == 1'b0, "R1 reset", sdo_oe, 0);
    check(sck == 1'b1, "R2 reset sck", sck, 1);

    // select during the first conversion
    cs_n = 1'b0;
    @(negedge clk);
    check(sdo_oe == 1'b1, "R1 selected", sdo_oe, 1);
    check(sdo == 1'b1, "R2 busy flag", sdo, 1);
    check(sck == 1'b0, "R2 sck low", sck, 0);
    cs_n = 1'b1;
    @(negedge clk);
    check(sdo_oe == 1'b0, "R1 deselected", sdo_oe, 0);
    repeat (CONV + 5) @(negedge clk);

    // R3: every pulse length short of the first rising edge
    for (int len = 1; len < EOCT + HALF; len++) begin
      bit bad = 1'b0;
      cs_n = 1'b0;
      repeat (len) begin
        @(negedge clk);
        if (sck || sdo || !sdo_oe) bad = 1'b1;
      end
      cs_n = 1'b1;
      repeat (3) @(negedge clk);
      if (sck !== 1'b1) bad = 1'b1;
      check(!bad, "R3 short select", len, 0);
    end

    // continuous readout with select held low
    for (int k = 0; k < NW; k++) begin
      if (k == 0) begin
        cs_n = 1'b0;
      end else begin
        count_conv(z, o, hi);
        check(z == HALF, "R7 tail", z, HALF);
        check(o == CONV, "R10 conv time", o, CONV);
        check(hi, "R7 sck idle high", hi, 1);
      end
      wait_first_rise(n);
      check(n == EOCT + HALF, "R4 window", n, EOCT + HALF);
      read_bits(32, w);
      set_inputs(k + 1);
      check(w == exp_word(k), "R6 word", w, exp_word(k));
      check(w[30] == k[0], "R9 channel", w[30], k[0]);
    end
    count_conv(z, o, hi);
    check(z == HALF && hi, "R7 final tail", z, HALF);
    check(o == CONV, "R10 final conv", o, CONV);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: aborts after 1, 7 and 31 rising edges
    c = NW;
    for (int j = 0; j < 3; j++) begin
      cs_n = 1'b0;
      wait_first_rise(n);
      check(n == EOCT + HALF, "R4 after select", n, EOCT + HALF);
      read_bits(nbs[j], w);
      check(w == (exp_word(c) >> (32 - nbs[j])), "R8 partial bits", w, exp_word(c) >> (32 - nbs[j]));
      set_inputs(c + 1);
      cs_n = 1'b1;
      @(negedge clk);
      check(sdo_oe == 1'b0, "R1 after abort", sdo_oe, 0);
      count_conv(z, o, hi);
      check(z == 0 && o == CONV, "R8 restart time", o, CONV);
      c++;
    end

    // R3: word converted while deselected is held for a full read
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    wait_first_rise(n);
    check(n == EOCT + HALF, "R4 held word", n, EOCT + HALF);
    read_bits(32, w);
    check(w == exp_word(c), "R3 held word", w, exp_word(c));
    check(w[30] == c[0], "R9 after aborts", w[30], c[0]);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule